// File: doc/BRIEF.md
# Multi-port timestamp counter

This block keeps one free-running time count and serves it to several clients at once. Each client owns a read port with no address: it raises a request for one cycle and, one cycle later, gets back a valid strobe and the count value that the block held in the request cycle. Every port has its own response register. Clients therefore need no shared multiplexer, and requests that arrive in the same cycle on different ports all see the same value.

The count advances once per time quantum. A prescaler that divides the clock by a parameter sets the quantum, and with a divide count of one the count moves on every clock. After reset the count is zero. When the block is built for time-of-day use, a control write can seed it with an absolute value, such as seconds since an epoch, and counting continues from that value. When it is built for local use, control writes have no effect and the count only runs up from reset. The count wraps modulo 2 to the power of its width.

Top module: `mport_tstamp`

## Requirements
- R1: While reset is held and on the first cycle after it, every `rd_valid` bit is 0, every port's `rd_data` is 0 and the count is 0.
- R2: `rd_valid[p]` is 1 in the cycle after `rd_req[p]` was 1, and 0 in the cycle after `rd_req[p]` was 0.
- R3: When `rd_valid[p]` is 1, port p's slice `rd_data[p*TS_W +: TS_W]` holds the count value of the cycle in which the request was made.
- R4: When two ports respond in the same cycle, their data are equal.
- R5: With no load, the count rises by exactly one on every TICK_DIV-th clock and holds in between. The prescaler phase starts at 0 after reset, so the first increment appears TICK_DIV cycles after reset is released.
- R6: With TICK_DIV = 1, the count rises by one on every clock.
- R7: With SEED_EN = 1, a cycle with `ld_valid` = 1 makes the count equal `ld_value` in the next cycle. This holds even when an increment falls in the same cycle. The prescaler phase does not change.
- R8: With SEED_EN = 0, `ld_valid` and `ld_value` have no effect on the count.
- R9: The count wraps from 2^TS_W - 1 to 0 on an increment.
- R10: A port with no response in a cycle keeps its previous `rd_data`. Requests on other ports do not disturb it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Control write strobe that seeds the count |
| ld_value | input | TS_W | Value loaded into the count |
| rd_req | input | NPORTS | One read request bit per port |
| rd_valid | output | NPORTS | One response strobe per port, one cycle after the request |
| rd_data | output | NPORTS*TS_W | Response data; port p occupies bits p*TS_W upward |

## Verification
The count is observable only through the ports' responses. A wrong count, a prescaler phase that has slipped, or a load that was missed or taken when it should not be therefore shows up on the first response that follows, which can be as soon as one cycle later. A response register that was fed the wrong value or updated without a request shows up as a mismatch against the data the port held before, or as two ports disagreeing in the same cycle. Reads run every cycle through load sweeps that cross every prescaler phase and across the wrap point, so a single bad increment is caught within one quantum.

// File: rtl/mport_tstamp_pkg.sv
package mport_tstamp_pkg;

  // Width of a prescaler phase counter for a given divide count.
  function automatic int unsigned div_cnt_w(input int unsigned div);
    return (div > 1) ? $clog2(div) : 1;
  endfunction

endpackage

// File: rtl/mport_tstamp_prescale.sv
module mport_tstamp_prescale
  import mport_tstamp_pkg::*;
#(
  parameter int unsigned TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int unsigned PW = div_cnt_w(TICK_DIV);

  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] phase;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                   phase <= phase + PW'(1);
      end

      assign tick = (phase == LAST);

      // Two ticks never fall in back-to-back cycles when dividing.
      assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/mport_tstamp_count.sv
module mport_tstamp_count #(
  parameter int unsigned TS_W    = 64,
  parameter bit          SEED_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            ld_valid,
  input  logic [TS_W-1:0] ld_value,
  output logic            ld_fire,
  output logic [TS_W-1:0] count
);

  function automatic logic [TS_W-1:0] bump(input logic [TS_W-1:0] v);
    return v + TS_W'(1);
  endfunction

  assign ld_fire = SEED_EN && ld_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (ld_fire) count <= ld_value;
    else if (tick)    count <= bump(count);
  end

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |=> count == $past(ld_value));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_fire && tick) |=> count == bump($past(count)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_fire && !tick) |=> $stable(count));

endmodule

// File: rtl/mport_tstamp_rdport.sv
module mport_tstamp_rdport #(
  parameter int unsigned TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [TS_W-1:0] ts,
  output logic            vld,
  output logic [TS_W-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      data <= '0;
    end else begin
      vld <= req;
      if (req) data <= ts;
    end
  end

  assert_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> vld);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !vld);

  assert_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(data));

  assert_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> data == $past(ts));

endmodule

// File: rtl/mport_tstamp.sv
module mport_tstamp #(
  parameter int unsigned TS_W     = 64,
  parameter int unsigned NPORTS   = 2,
  parameter int unsigned TICK_DIV = 1,
  parameter bit          SEED_EN  = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_valid,
  input  logic [TS_W-1:0]          ld_value,
  input  logic [NPORTS-1:0]        rd_req,
  output logic [NPORTS-1:0]        rd_valid,
  output logic [NPORTS*TS_W-1:0]   rd_data
);

  logic            tick;
  logic            ld_fire;
  logic [TS_W-1:0] count;

  mport_tstamp_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  mport_tstamp_count #(.TS_W(TS_W), .SEED_EN(SEED_EN)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .ld_valid(ld_valid),
    .ld_value(ld_value),
    .ld_fire (ld_fire),
    .count   (count)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    mport_tstamp_rdport #(.TS_W(TS_W)) u_rd (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (rd_req[p]),
      .ts   (count),
      .vld  (rd_valid[p]),
      .data (rd_data[p*TS_W +: TS_W])
    );
  end

  if (NPORTS > 1) begin : g_same
    assert_same_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid[0] && rd_valid[1]) |-> rd_data[0 +: TS_W] == rd_data[TS_W +: TS_W]);
  end

  if (!SEED_EN) begin : g_local
    assert_ignore_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !tick) |=> $stable(count));
  end

endmodule

// File: tb/mport_tstamp_tb.sv
module mport_tstamp_tb;
  localparam int W = 8;
  localparam int NP = 2;
  localparam int DIV = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            ld_valid = 1'b0;
  logic [W-1:0]    ld_value = '0;
  logic [NP-1:0]   rd_req = '0;
  logic [NP-1:0]   a_vld, b_vld;
  logic [NP*W-1:0] a_dat, b_dat;

  // Time-of-day build, divided quantum.
  mport_tstamp #(.TS_W(W), .NPORTS(NP), .TICK_DIV(DIV), .SEED_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_value(ld_value),
    .rd_req(rd_req), .rd_valid(a_vld), .rd_data(a_dat));

  // Local build, tick every clock.
  mport_tstamp #(.TS_W(W), .NPORTS(NP), .TICK_DIV(1), .SEED_EN(1'b0)) u_dut_loc (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_value(ld_value),
    .rd_req(rd_req), .rd_valid(b_vld), .rd_data(b_dat));

  int n_chk = 0;
  int n_bad = 0;
  string tag_a = "R3";

  task automatic chk(input string tag, input logic ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Arithmetic reference: phase counter and two counts.
  int           mphase;
  logic [W-1:0] ma, mb;
  logic [NP-1:0] ea_v, eb_v;
  logic [W-1:0] ea_d [NP];
  logic [W-1:0] eb_d [NP];

  always @(posedge clk) begin
    if (!rst_n) begin
      mphase <= 0; ma <= '0; mb <= '0; ea_v <= '0; eb_v <= '0;
      for (int p = 0; p < NP; p++) begin ea_d[p] <= '0; eb_d[p] <= '0; end
    end else begin
      mphase <= (mphase + 1) % DIV;
      if (ld_valid)            ma <= ld_value;
      else if (mphase == DIV-1) ma <= ma + 8'd1;
      mb <= mb + 8'd1;
      ea_v <= rd_req; eb_v <= rd_req;
      for (int p = 0; p < NP; p++)
        if (rd_req[p]) begin ea_d[p] <= ma; eb_d[p] <= mb; end
    end
  end

  logic run_chk = 1'b0;
  always @(negedge clk) begin
    if (run_chk) begin
      for (int p = 0; p < NP; p++) begin
        chk("R2", a_vld[p] == ea_v[p], a_vld[p], ea_v[p]);
        chk("R2", b_vld[p] == eb_v[p], b_vld[p], eb_v[p]);
        chk(ea_v[p] ? tag_a : "R10", a_dat[p*W +: W] == ea_d[p], a_dat[p*W +: W], ea_d[p]);
        chk(eb_v[p] ? "R6 R8 R9" : "R10", b_dat[p*W +: W] == eb_d[p], b_dat[p*W +: W], eb_d[p]);
      end
      if (a_vld[0] && a_vld[1])
        chk("R4", a_dat[0 +: W] == a_dat[W +: W], a_dat[0 +: W], a_dat[W +: W]);
      if (b_vld[0] && b_vld[1])
        chk("R4", b_dat[0 +: W] == b_dat[W +: W], b_dat[0 +: W], b_dat[W +: W]);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", a_vld == '0, a_vld, 0);
    chk("R1", b_vld == '0, b_vld, 0);
    chk("R1", a_dat == '0, a_dat, 0);
    chk("R1", b_dat == '0, b_dat, 0);
    rst_n = 1'b1;
    run_chk = 1'b1;

    // R3 R5: read every cycle on both ports
    tag_a = "R3 R5";
    rd_req = 2'b11;
    repeat (20) @(negedge clk);

    // R10: port patterns one at a time
    tag_a = "R10";
    for (int i = 0; i < 24; i++) begin
      rd_req = (i % 3 == 0) ? 2'b01 : (i % 3 == 1) ? 2'b10 : 2'b00;
      @(negedge clk);
    end

    // R7: loads across every prescaler phase, some coinciding with a tick
    tag_a = "R7";
    rd_req = 2'b11;
    for (int k = 0; k < 6; k++) begin
      ld_valid = 1'b1; ld_value = 8'h40 + 8'(k * 16);
      @(negedge clk);
      ld_valid = 1'b0;
      repeat (4) @(negedge clk);
    end

    // R9: seed near the top and cross the wrap point
    tag_a = "R9";
    ld_valid = 1'b1; ld_value = 8'hFC;
    @(negedge clk);
    ld_valid = 1'b0;
    repeat (30) @(negedge clk);

    // Mixed pseudo-random requests and loads; local build wraps several times
    tag_a = "R3 R7";
    for (int i = 0; i < 700; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd_req = lfsr[1:0];
      ld_valid = (lfsr[7:4] == 4'h0);
      ld_value = lfsr[15:8];
      @(negedge clk);
    end
    ld_valid = 1'b0; rd_req = '0;
    repeat (3) @(negedge clk);
    run_chk = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule